// File: doc/BRIEF.md
# Logarithmic-to-Floating-Point Converter

This block takes a value in a logarithmic number format and turns it into a floating-point word. The input word holds a two-bit class code, a sign, and a signed fixed-point base-2 logarithm. The floating-point output holds a sign, a biased exponent and a significand with a hidden leading one. The integer part of the logarithm becomes the unbiased exponent. The fractional part f becomes the significand through the value 2^f, which lies in [1,2).

A single table indexed by the whole fraction would grow exponentially with its width. The block therefore cuts the fraction into three equal bit fields. It reads one small table per field and multiplies the three factors, since 2^f is the product of 2 raised to each field's weighted value. Each table entry is computed when the design elaborates. The converter is a two-stage pipeline: the first stage reads the tables and registers the factors, and the second stage multiplies, rounds, classifies and registers the packed word. A valid strobe travels alongside the data.

The input word is laid out as {class[1:0], sign, log}, where log = {integer part (INT_W bits, two's complement), fraction (FRAC_W bits)}. The output word is {sign, exponent (EXP_W bits), significand (MAN_W bits)}. Input class codes are 00 ordinary number, 01 zero, 10 infinity and 11 not-a-number. The second stage sorts each result into one of four named output classes: NORMAL, ZERO, INF and NAN.

Top module: `lns2fp_conv`

## Requirements
- R1: `out_valid` equals `in_valid` from two rising clock edges earlier. A cycle with `in_valid` low produces a cycle with `out_valid` low two edges later.
- R2: Input class 01 (zero) gives an all-zero exponent and an all-zero significand.
- R3: Input class 10 (infinity) gives an all-ones exponent and an all-zero significand.
- R4: Input class 11 (not-a-number) gives an all-ones exponent and a significand whose top bit is 1 and whose other bits are 0.
- R5: For class 00, the fraction is split into three fields of FRAC_W/3 bits. The field whose least significant bit sits at fraction bit p indexes a table holding round(2^(k·2^(p−FRAC_W)) · 2^TW), where TW = MAN_W+GUARD fraction bits. The three entries are multiplied. The product is rounded to MAN_W fraction bits, with round-to-nearest and ties going up. The exponent is the integer part plus BIAS = 2^(EXP_W−1)−1.
- R6: If rounding makes the significand reach 2.0, the stored significand is 0 and the exponent is one higher than the R5 value.
- R7: For class 00, when integer part + BIAS + rounding carry is at least 2^EXP_W−1, the output is the infinity encoding of R3.
- R8: For class 00, when integer part + BIAS + rounding carry is 0 or less, the output is the zero encoding of R2. No subnormals are produced.
- R9: The output sign bit equals the input sign bit in every class.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_fp` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_lns | input | INT_W+FRAC_W+3 | {class, sign, integer part, fraction} |
| out_valid | output | 1 | Output word is present this cycle |
| out_fp | output | EXP_W+MAN_W+1 | {sign, biased exponent, significand} |

## Verification
The assertions assume that the product of the three table factors stays below 2.0. This holds for the default widths, because the largest fraction maps to about 1.98 and the table rounding error is far smaller than the remaining gap. The checker rebuilds the class, sign and integer part from a two-cycle delayed copy of the input. For that reason the exponent is pinned only to a window of two values, and the exact significand is left to the bench. The stimulus sweeps every log value, with both signs and all four class codes, under the default widths. Idle cycles are inserted so that the strobe alignment is exercised with data that must be ignored.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // Class code carried in the top two bits of the logarithmic input word.
    typedef enum logic [1:0] {
        LNS_NUM  = 2'b00,
        LNS_ZERO = 2'b01,
        LNS_INF  = 2'b10,
        LNS_NAN  = 2'b11
    } lns_flag_e;

    // Class chosen for the packed floating-point result.
    typedef enum logic [1:0] {
        OUT_NORMAL,
        OUT_ZERO,
        OUT_INF,
        OUT_NAN
    } out_kind_e;

endpackage

// File: rtl/lf_exp_rom.sv
module lf_exp_rom #(
    parameter int FRAC_W  = 6,
    parameter int LSB     = 0,
    parameter int FIELD_W = 2,
    parameter int TW      = 8
) (
    input  logic [FIELD_W-1:0] idx,
    output logic [TW:0]        val
);

    localparam int DEPTH = 1 << FIELD_W;
    localparam int ENT_W = TW + 1;

    // Entry k is 2 raised to (k weighted by this field's position), stored
    // with TW fraction bits and rounded to nearest.
    function automatic logic [TW:0] entry(input int k);
        real x;
        x = real'(k * (1 << LSB)) / real'(1 << FRAC_W);
        entry = ENT_W'($rtoi((2.0 ** x) * real'(1 << TW) + 0.5));
    endfunction

    logic [TW:0] tab [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        assign tab[k] = entry(k);
    end

    assign val = tab[idx];

endmodule

// File: rtl/lf_round_pack.sv
module lf_round_pack #(
    parameter int INT_W = 5,
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int TW    = 8
) (
    input  logic                    sign,
    input  logic signed [INT_W-1:0] ipart,
    input  lf_pkg::lns_flag_e       flag,
    input  logic [TW:0]             fa,
    input  logic [TW:0]             fb,
    input  logic [TW:0]             fc,
    output logic [EXP_W+MAN_W:0]    word
);
    import lf_pkg::*;

    localparam int PW   = 3 * (TW + 1);
    localparam int FB   = 3 * TW;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 1;

    logic [PW-1:0]      prod;
    logic [MAN_W+1:0]   sig_r;
    logic               carry;
    logic [MAN_W-1:0]   man;
    int                 e_val;
    out_kind_e          kind;

    // Product of three factors in [1,2): one integer bit at position FB.
    assign prod  = PW'(fa) * PW'(fb) * PW'(fc);
    assign sig_r = {1'b0, prod[FB -: MAN_W+1]} + (MAN_W+2)'(prod[FB-MAN_W-1]);
    assign carry = sig_r[MAN_W+1];
    assign man   = carry ? '0 : sig_r[MAN_W-1:0];

    always_comb begin
        e_val = int'(ipart) + BIAS + int'(carry);
    end

    // Result classification.
    always_comb begin
        kind = OUT_NAN;
        unique case (flag)
            LNS_NUM: begin
                if (e_val <= 0)
                    kind = OUT_ZERO;
                else if (e_val >= EMAX)
                    kind = OUT_INF;
                else
                    kind = OUT_NORMAL;
            end
            LNS_ZERO: kind = OUT_ZERO;
            LNS_INF:  kind = OUT_INF;
            LNS_NAN:  kind = OUT_NAN;
        endcase
    end

    // Word assembly per class.
    always_comb begin
        word = '0;
        unique case (kind)
            OUT_NORMAL: word = {sign, e_val[EXP_W-1:0], man};
            OUT_ZERO:   word = {sign, {EXP_W{1'b0}}, {MAN_W{1'b0}}};
            OUT_INF:    word = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            OUT_NAN:    word = {sign, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{prod[PW-1:FB+1], prod[FB-MAN_W-2:0], e_val[31:EXP_W]};

endmodule

// File: rtl/lns2fp_conv.sv
module lns2fp_conv #(
    parameter int INT_W = 5,
    parameter int FRAC_W = 6,
    parameter int EXP_W = 4,
    parameter int MAN_W = 4,
    parameter int GUARD = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [INT_W+FRAC_W+2:0]     in_lns,
    output logic                        out_valid,
    output logic [EXP_W+MAN_W:0]        out_fp
);
    import lf_pkg::*;

    localparam int LOG_W = INT_W + FRAC_W;
    localparam int W_IN  = LOG_W + 3;
    localparam int FW    = FRAC_W / 3;
    localparam int TW    = MAN_W + GUARD;

    // Stage 1: table reads.
    logic [TW:0] tab_val [3];

    for (genvar g = 0; g < 3; g++) begin : g_field
        lf_exp_rom #(
            .FRAC_W (FRAC_W),
            .LSB    (g * FW),
            .FIELD_W(FW),
            .TW     (TW)
        ) u_rom (
            .idx(in_lns[g*FW +: FW]),
            .val(tab_val[g])
        );
    end

    logic                    s1_valid;
    logic                    s1_sign;
    logic signed [INT_W-1:0] s1_int;
    lns_flag_e               s1_flag;
    logic [TW:0]             s1_fac [3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_int   <= '0;
            s1_flag  <= LNS_NUM;
            for (int i = 0; i < 3; i++) s1_fac[i] <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= in_lns[LOG_W];
            s1_int   <= in_lns[LOG_W-1:FRAC_W];
            s1_flag  <= lns_flag_e'(in_lns[W_IN-1 -: 2]);
            for (int i = 0; i < 3; i++) s1_fac[i] <= tab_val[i];
        end
    end

    // Stage 2: multiply, round, classify, pack.
    logic [EXP_W+MAN_W:0] packed_word;

    lf_round_pack #(
        .INT_W(INT_W),
        .EXP_W(EXP_W),
        .MAN_W(MAN_W),
        .TW   (TW)
    ) u_pack (
        .sign (s1_sign),
        .ipart(s1_int),
        .flag (s1_flag),
        .fa   (s1_fac[0]),
        .fb   (s1_fac[1]),
        .fc   (s1_fac[2]),
        .word (packed_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fp    <= '0;
        end else begin
            out_valid <= s1_valid;
            out_fp    <= packed_word;
        end
    end

endmodule

// File: rtl/lns2fp_chk.sv
module lns2fp_chk #(
    parameter int INT_W = 5,
    parameter int FRAC_W = 6,
    parameter int EXP_W = 4,
    parameter int MAN_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [INT_W+FRAC_W+2:0]  in_lns,
    input logic                     out_valid,
    input logic [EXP_W+MAN_W:0]     out_fp
);
    localparam int LOG_W = INT_W + FRAC_W;
    localparam int W_IN  = LOG_W + 3;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX  = (1 << EXP_W) - 1;

    logic [W_IN-1:0] lns_d1, lns_d2;
    logic            v_d1, v_d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lns_d1 <= '0;
            lns_d2 <= '0;
            v_d1   <= 1'b0;
            v_d2   <= 1'b0;
        end else begin
            lns_d1 <= in_lns;
            lns_d2 <= lns_d1;
            v_d1   <= in_valid;
            v_d2   <= v_d1;
        end
    end

    logic [1:0]              d_flag;
    logic                    d_sign;
    logic signed [INT_W-1:0] d_int;
    int                      d_e;
    logic [EXP_W-1:0]        o_exp;
    logic [MAN_W-1:0]        o_man;
    logic                    o_sign;

    assign d_flag = lns_d2[W_IN-1 -: 2];
    assign d_sign = lns_d2[LOG_W];
    assign d_int  = lns_d2[LOG_W-1:FRAC_W];
    always_comb d_e = int'(d_int) + BIAS;
    assign o_exp  = out_fp[EXP_W+MAN_W-1:MAN_W];
    assign o_man  = out_fp[MAN_W-1:0];
    assign o_sign = out_fp[EXP_W+MAN_W];

    p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_d2);

    p_zero_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b01) |-> (o_exp == '0 && o_man == '0));

    p_inf_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b10) |-> (&o_exp && o_man == '0));

    p_nan_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b11) |-> (&o_exp && o_man[MAN_W-1]));

    p_exp_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b00 && d_e >= 1 && d_e <= EMAX - 2)
        |-> (int'(o_exp) == d_e || int'(o_exp) == d_e + 1));

    p_carry_zero_man_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b00 && d_e >= 1 && d_e <= EMAX - 2
         && int'(o_exp) == d_e + 1) |-> (o_man == '0));

    p_overflow_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b00 && d_e >= EMAX) |-> (&o_exp && o_man == '0));

    p_underflow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_flag == 2'b00 && d_e < 0) |-> (o_exp == '0 && o_man == '0));

    p_sign_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (o_sign == d_sign));

endmodule

bind lns2fp_conv lns2fp_chk #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_lns   (in_lns),
    .out_valid(out_valid),
    .out_fp   (out_fp)
);

// File: tb/test_lns2fp_conv.sv
module test_lns2fp_conv;

    localparam int INT_W  = 5;
    localparam int FRAC_W = 6;
    localparam int EXP_W  = 4;
    localparam int MAN_W  = 4;
    localparam int GUARD  = 4;
    localparam int TW     = MAN_W + GUARD;
    localparam int FW     = FRAC_W / 3;
    localparam int LOG_W  = INT_W + FRAC_W;
    localparam int W_IN   = LOG_W + 3;
    localparam int W_OUT  = EXP_W + MAN_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [W_IN-1:0]  in_lns = '0;
    logic             out_valid;
    logic [W_OUT-1:0] out_fp;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lns2fp_conv #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W),
        .MAN_W(MAN_W), .GUARD(GUARD)
    ) i_lns2fp_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lns(in_lns),
        .out_valid(out_valid), .out_fp(out_fp)
    );

    bit               qv [$];
    logic [W_OUT-1:0] qf [$];
    string            qt [$];

    function automatic longint tab_entry(input int k, input int lsb);
        real x;
        x = real'(k * (1 << lsb)) / real'(1 << FRAC_W);
        return longint'($rtoi((2.0 ** x) * real'(1 << TW) + 0.5));
    endfunction

    function automatic void model(input logic [W_IN-1:0] x,
                                  output logic [W_OUT-1:0] y, output string tag);
        int     flag, sgn, ip, fr, e, carry;
        longint prod, sig, rb;
        flag = int'(x[W_IN-1 -: 2]);
        sgn  = int'(x[LOG_W]);
        ip   = int'(x[LOG_W-1:FRAC_W]);
        if (ip >= (1 << (INT_W - 1))) ip -= (1 << INT_W);
        fr   = int'(x[FRAC_W-1:0]);
        prod = 1;
        for (int g = 0; g < 3; g++)
            prod *= tab_entry((fr >> (g * FW)) & ((1 << FW) - 1), g * FW);
        sig   = prod >> (3 * TW - MAN_W);
        rb    = (prod >> (3 * TW - MAN_W - 1)) & 1;
        sig  += rb;
        carry = (sig >= (longint'(2) << MAN_W)) ? 1 : 0;
        e     = ip + BIAS + carry;
        case (flag)
            1: begin y = {sgn[0], {EXP_W{1'b0}}, {MAN_W{1'b0}}}; tag = "R2 R9"; end
            2: begin y = {sgn[0], {EXP_W{1'b1}}, {MAN_W{1'b0}}}; tag = "R3 R9"; end
            3: begin y = {sgn[0], {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}}; tag = "R4 R9"; end
            default: begin
                if (e <= 0) begin
                    y = {sgn[0], {EXP_W{1'b0}}, {MAN_W{1'b0}}}; tag = "R8 R9";
                end else if (e >= EMAX) begin
                    y = {sgn[0], {EXP_W{1'b1}}, {MAN_W{1'b0}}}; tag = "R7 R9";
                end else if (carry != 0) begin
                    y = {sgn[0], e[EXP_W-1:0], {MAN_W{1'b0}}}; tag = "R6 R9";
                end else begin
                    y = {sgn[0], e[EXP_W-1:0], sig[MAN_W-1:0]}; tag = "R5 R9";
                end
            end
        endcase
    endfunction

    task automatic check_head();
        bit               ev;
        logic [W_OUT-1:0] ef;
        string            et;
        ev = qv.pop_front();
        ef = qf.pop_front();
        et = qt.pop_front();
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, ev);
        end else if (ev && out_fp !== ef) begin
            errors++;
            $display("FAIL %s out_fp actual=%h expected=%h", et, out_fp, ef);
        end
    endtask

    task automatic step(input bit v, input logic [W_IN-1:0] x);
        logic [W_OUT-1:0] y;
        string            t;
        @(negedge clk);
        if (qv.size() == 2) check_head();
        in_valid = v;
        in_lns   = x;
        model(x, y, t);
        qv.push_back(v);
        qf.push_back(y);
        qt.push_back(v ? t : "R1");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_fp !== '0) begin
            errors++;
            $display("FAIL R10 reset actual=%0b/%h expected=0/%h", out_valid, out_fp, {W_OUT{1'b0}});
        end
        rst_n = 1'b1;
        for (int fl = 0; fl < 4; fl++) begin
            for (int s = 0; s < 2; s++) begin
                for (int lg = 0; lg < (1 << LOG_W); lg++) begin
                    step(1'b1, {fl[1:0], s[0], lg[LOG_W-1:0]});
                    // R1: idle bubble carrying data that must be ignored
                    if ((lg % 13) == 5)
                        step(1'b0, {fl[1:0], ~s[0], ~lg[LOG_W-1:0]});
                end
            end
        end
        step(1'b0, '0);
        step(1'b0, '0);
        @(negedge clk);
        check_head();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

endmodule